// File: doc/BRIEF.md
# Clock Fan-Out Output-Enable Controller

This block is the digital control core of a clock distribution buffer that copies one reference clock onto six output pairs and one feedback output. Software programs the outputs over a two-wire SMBus link. The controller acts as a write-only slave that answers one fixed 7-bit address. It takes a block-write frame and keeps two of the data bytes as per-output enable bits. All other bytes are acknowledged and then dropped.

In the reference clock domain, each enabled output follows the reference clock. A disabled output is held low. Enable changes take effect only on a falling edge of the reference clock, so no shortened pulses appear. A mode select makes each pair either complementary (double-data-rate memory) or in-phase (single-data-rate memory). An active-low power-down input overrides everything and forces every output low.

Top module: `clkfan_oe_ctrl`

## Requirements
- R1: Only a write to address 1101001 (address byte 0xD2, R/W bit 0 in the least significant position) is acknowledged. Any other address, or a read to this address, gets no acknowledge, and the data that follows has no effect on the outputs.
- R2: Within an addressed frame, every byte is acknowledged by pulling SDA low during the ninth SCL pulse. This includes data bytes at index 8 and above, which are discarded.
- R3: The frame is address, command byte, byte count, then data bytes. Data bytes are numbered 0, 1, 2 and so on from the first byte after the count. Each byte is received most significant bit first. Only data bytes 6 and 7 change any enable.
- R4: Data byte 6 sets the enables as follows: bit 4 for the feedback output, bit 3 for pair 5, bit 1 for pair 4.
- R5: Data byte 7 sets the enables as follows: bit 6 for pair 3, bit 5 for pair 2, bit 2 for pair 1, bit 0 for pair 0.
- R6: Writing reserved bits (byte 6 bits 7, 6, 5, 2, 0 and byte 7 bits 7, 4, 3, 1) has no effect on any output.
- R7: After reset every output is enabled and the SDA pull-down is released.
- R8: An enable bit of 1 makes the output follow the reference clock, and 0 holds it low. A new enable value reaches the outputs on the first reference falling edge after two reference rising edges have passed since the register update.
- R9: While the power-down input is low, all true, complement and feedback outputs are low, whatever the enables are.
- R10: With the mode select high, each enabled pair drives the reference clock on its true output and the inverted clock on its complement output. With the mode select low, both outputs carry the reference clock in phase.
- R11: A START condition at any point, including a repeated START inside a frame, restarts address decoding and data byte numbering. A STOP ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Oversampling clock for the SMBus lines |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SMBus clock line |
| sda_in | input | 1 | SMBus data line, as seen on the wire |
| sda_pull_low | output | 1 | High when the slave pulls SDA low to acknowledge |
| ref_clk | input | 1 | Reference clock to be distributed |
| pwr_dn_n | input | 1 | Active-low power-down; low forces all outputs low |
| ddr_sel | input | 1 | 1: complementary pairs, 0: in-phase pairs |
| clk_t | output | 6 | True output of each pair |
| clk_c | output | 6 | Complement output of each pair |
| fb_clk | output | 1 | Feedback clock output |

## Verification
The acknowledge for a byte appears about three system cycles after the eighth SCL falling edge. The bench samples it in the middle of the ninth SCL high phase, far from either edge. An enable write lands in the register during that acknowledge. It then crosses into the reference domain and reaches the outputs at most three reference periods later. The model applies the write only after the STOP, and output comparison pauses for four reference periods while the change settles. Mode select and power-down act on the outputs without delay, so they are compared two nanoseconds after every reference edge, both rising and falling, against a model built from the expected enables and the known clock phase.

// File: rtl/fogc_pkg.sv
`timescale 1ns/1ps
package fogc_pkg;
   localparam int unsigned NPAIR = 6;
   localparam int unsigned NOUT  = NPAIR + 1;   // top index is the feedback output

   typedef enum logic [1:0] {SMB_IDLE, SMB_ADDR, SMB_HDR, SMB_DATA} smb_st_t;

   // 1 when output k is enabled from the second configuration byte
   function automatic bit oe_in_hi_byte(input int unsigned k);
      return (k < 4);
   endfunction

   // bit position of output k inside its configuration byte
   function automatic int unsigned oe_bit_pos(input int unsigned k);
      case (k)
         0:       return 0;
         1:       return 2;
         2:       return 5;
         3:       return 6;
         4:       return 1;
         5:       return 3;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/fogc_sync.sv
`timescale 1ns/1ps
module fogc_sync #(
   parameter int unsigned   W       = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fogc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fogc_smb_wr.sv
`timescale 1ns/1ps
module fogc_smb_wr import fogc_pkg::*; #(
   parameter logic [6:0]  SLAVE_ADDR  = 7'b1101001,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HDR_BYTES   = 2,
   parameter int unsigned IDX_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl,
   input  logic             sda,
   output logic             sda_pull,
   output logic             wr_stb,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data
);
   localparam int unsigned HL_W = $clog2(HDR_BYTES + 1);

   if (HDR_BYTES < 1) begin : g_bad_hdr
      $error("fogc_smb_wr: HDR_BYTES must be at least 1");
   end
   if (IDX_W < 4) begin : g_bad_idx
      $error("fogc_smb_wr: IDX_W must be at least 4");
   end

   logic [1:0]       lines_s;
   logic             scl_s, sda_s, scl_d, sda_d;
   logic             start_ev, stop_ev, scl_rise, scl_fall;
   smb_st_t          st;
   logic             in_ack;
   logic [3:0]       bit_cnt;
   logic [7:0]       shreg;
   logic [HL_W-1:0]  hdr_left;
   logic [IDX_W-1:0] data_idx;

   fogc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
      .clk(clk), .rst_n(rst_n), .d({scl, sda}), .q(lines_s));
   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SMB_IDLE;
         in_ack   <= 1'b0;
         sda_pull <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         hdr_left <= '0;
         data_idx <= '0;
         wr_stb   <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_ev) begin
            st       <= SMB_ADDR;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            hdr_left <= HL_W'(HDR_BYTES);
            data_idx <= '0;
         end else if (stop_ev) begin
            st       <= SMB_IDLE;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
         end else if (st != SMB_IDLE) begin
            if (scl_rise && !in_ack && bit_cnt != 4'd8) begin
               shreg   <= {shreg[6:0], sda_s};
               bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall) begin
               if (in_ack) begin
                  in_ack   <= 1'b0;
                  sda_pull <= 1'b0;
                  bit_cnt  <= '0;
               end else if (bit_cnt == 4'd8) begin
                  case (st)
                     SMB_ADDR: begin
                        if (shreg == {SLAVE_ADDR, 1'b0}) begin
                           in_ack   <= 1'b1;
                           sda_pull <= 1'b1;
                           st       <= SMB_HDR;
                        end else begin
                           st <= SMB_IDLE;
                        end
                     end
                     SMB_HDR: begin
                        in_ack   <= 1'b1;
                        sda_pull <= 1'b1;
                        hdr_left <= hdr_left - HL_W'(1);
                        if (hdr_left == HL_W'(1)) st <= SMB_DATA;
                     end
                     SMB_DATA: begin
                        in_ack   <= 1'b1;
                        sda_pull <= 1'b1;
                        wr_stb   <= 1'b1;
                        wr_idx   <= data_idx;
                        wr_data  <= shreg;
                        if (data_idx != '1) data_idx <= data_idx + IDX_W'(1);
                     end
                     default: st <= SMB_IDLE;
                  endcase
               end
            end
         end
      end
   end

   // R2: the acknowledge level only moves while SCL is low
   a_r2_ack_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !scl_s);

   // R3: a data strobe is always accompanied by an acknowledge
   a_r3_stb_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sda_pull);

   // R11: a START restarts address decoding and byte numbering
   a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == SMB_ADDR && !sda_pull && data_idx == '0));
endmodule

// File: rtl/fogc_oe_regs.sv
`timescale 1ns/1ps
module fogc_oe_regs import fogc_pkg::*; #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned CFG_A = 6,
   parameter int unsigned CFG_B = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   output logic [NOUT-1:0]  oe
);
   if (CFG_A == CFG_B) begin : g_bad_cfg
      $error("fogc_oe_regs: CFG_A and CFG_B must differ");
   end
   if (CFG_A >= (1 << IDX_W) - 1 || CFG_B >= (1 << IDX_W) - 1) begin : g_bad_range
      $error("fogc_oe_regs: configuration index beyond saturating index range");
   end

   logic unused_rsvd;
   assign unused_rsvd = ^wr_data;

   for (genvar k = 0; k < NOUT; k++) begin : g_oe
      localparam int unsigned SEL_IDX = oe_in_hi_byte(k) ? CFG_B : CFG_A;
      localparam int unsigned BITP    = oe_bit_pos(k);
      logic en_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      en_r <= 1'b1;
         else if (wr_stb && wr_idx == IDX_W'(SEL_IDX))    en_r <= wr_data[BITP];
      end
      assign oe[k] = en_r;
   end

   // R6: bytes other than the two configuration bytes leave the enables alone
   a_r6_other_bytes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_idx != IDX_W'(CFG_A) && wr_idx != IDX_W'(CFG_B)) |=> $stable(oe));

   // R3: without a data strobe the enables hold
   a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(oe));
endmodule

// File: rtl/fogc_gate.sv
`timescale 1ns/1ps
module fogc_gate import fogc_pkg::*; #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic [NOUT-1:0]  oe_sys,
   input  logic             pwr_dn_n,
   input  logic             ddr_sel,
   output logic [NPAIR-1:0] clk_t,
   output logic [NPAIR-1:0] clk_c,
   output logic             fb_clk
);
   logic            rrst_n;
   logic [NOUT-1:0] oe_r;
   logic [NOUT-1:0] en_q;

   fogc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

   fogc_sync #(.W(NOUT), .STAGES(SYNC_STAGES), .RST_VAL({NOUT{1'b1}})) u_oe_sync (
      .clk(ref_clk), .rst_n(rrst_n), .d(oe_sys), .q(oe_r));

   // enables change only while the reference clock is low
   always_ff @(negedge ref_clk or negedge rrst_n) begin
      if (!rrst_n) en_q <= '1;
      else         en_q <= oe_r;
   end

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      assign clk_t[k] = ref_clk & en_q[k] & pwr_dn_n;
      assign clk_c[k] = (ref_clk ^ ddr_sel) & en_q[k] & pwr_dn_n;
   end
   assign fb_clk = ref_clk & en_q[NPAIR] & pwr_dn_n;

   // R9: power-down holds every output low, even complements while the clock is low
   a_r9_pd_forces_low: assert property (@(posedge ref_clk) disable iff (!rrst_n)
      !pwr_dn_n |-> (clk_t == '0 && clk_c == '0 && !fb_clk));

   // R10: complementary mode drives enabled complements high while the clock is low
   a_r10_ddr_complement: assert property (@(posedge ref_clk) disable iff (!rrst_n)
      (pwr_dn_n && ddr_sel) |-> (clk_c == en_q[NPAIR-1:0] && clk_t == '0));

   // R10: in-phase mode keeps both outputs low while the clock is low
   a_r10_sdram_inphase: assert property (@(posedge ref_clk) disable iff (!rrst_n)
      !ddr_sel |-> (clk_c == '0 && clk_t == '0));
endmodule

// File: rtl/clkfan_oe_ctrl.sv
`timescale 1ns/1ps
module clkfan_oe_ctrl import fogc_pkg::*; #(
   parameter logic [6:0]  SLAVE_ADDR  = 7'b1101001,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HDR_BYTES   = 2,
   parameter int unsigned IDX_W       = 4
) (
   input  logic             sys_clk,
   input  logic             sys_rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_pull_low,
   input  logic             ref_clk,
   input  logic             pwr_dn_n,
   input  logic             ddr_sel,
   output logic [NPAIR-1:0] clk_t,
   output logic [NPAIR-1:0] clk_c,
   output logic             fb_clk
);
   logic             wr_stb;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_data;
   logic [NOUT-1:0]  oe;

   fogc_smb_wr #(
      .SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(SYNC_STAGES),
      .HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)
   ) u_smb (
      .clk(sys_clk), .rst_n(sys_rst_n), .scl(scl_in), .sda(sda_in),
      .sda_pull(sda_pull_low), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data));

   fogc_oe_regs #(.IDX_W(IDX_W), .CFG_A(6), .CFG_B(7)) u_regs (
      .clk(sys_clk), .rst_n(sys_rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .oe(oe));

   fogc_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .ref_clk(ref_clk), .rst_n(sys_rst_n), .oe_sys(oe), .pwr_dn_n(pwr_dn_n),
      .ddr_sel(ddr_sel), .clk_t(clk_t), .clk_c(clk_c), .fb_clk(fb_clk));
endmodule

// File: tb/clkfan_oe_ctrl_tb.sv
`timescale 1ns/1ps
module clkfan_oe_ctrl_tb;
   localparam int Q = 40;   // SMBus quarter bit period in ns

   logic       sys_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       sys_rst_n;
   logic       scl_m, sda_m;
   logic       sda_line;
   logic       sda_pull;
   logic       pwr_dn_n, ddr_sel;
   logic [5:0] clk_t, clk_c;
   logic       fb_clk;

   int         n_chk  = 0;
   int         n_fail = 0;
   bit         chk_on = 1'b0;
   string      cur_tag = "R7";
   logic [6:0] exp_oe;            // [6] feedback, [5:0] pairs
   logic [7:0] tx_q[$];
   int         pidx_q[$];
   logic [7:0] pdat_q[$];

   always #2 sys_clk = ~sys_clk;  // 250 MHz
   always #6 ref_clk = ~ref_clk;

   assign sda_line = sda_m & ~sda_pull;

   clkfan_oe_ctrl u_dut (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_pull_low(sda_pull), .ref_clk(ref_clk), .pwr_dn_n(pwr_dn_n), .ddr_sel(ddr_sel),
      .clk_t(clk_t), .clk_c(clk_c), .fb_clk(fb_clk));

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
   endtask

   // behavioural reference of the outputs at a known clock level
   task automatic compare(input logic lvl);
      logic [5:0] et, ec;
      logic       ef;
      for (int k = 0; k < 6; k++) begin
         et[k] = pwr_dn_n & exp_oe[k] & lvl;
         ec[k] = pwr_dn_n & exp_oe[k] & (ddr_sel ? ~lvl : lvl);
      end
      ef = pwr_dn_n & exp_oe[6] & lvl;
      n_chk++;
      if ({clk_t, clk_c, fb_clk, sda_pull} !== {et, ec, ef, 1'b0}) begin
         n_fail++;
         $display("FAIL %s lvl=%b: t=%b c=%b fb=%b pull=%b expected t=%b c=%b fb=%b pull=0",
                  cur_tag, lvl, clk_t, clk_c, fb_clk, sda_pull, et, ec, ef);
      end
   endtask

   always begin
      @(posedge ref_clk); #2;
      if (chk_on) compare(1'b1);
      @(negedge ref_clk); #2;
      if (chk_on) compare(1'b0);
   end

   task automatic model_byte(input int idx, input logic [7:0] b);
      case (idx)
         6: begin exp_oe[6] = b[4]; exp_oe[5] = b[3]; exp_oe[4] = b[1]; end
         7: begin exp_oe[3] = b[6]; exp_oe[2] = b[5]; exp_oe[1] = b[2]; exp_oe[0] = b[0]; end
         default: ;
      endcase
   endtask

   task automatic align();
      @(posedge sys_clk); #1;
   endtask

   task automatic wait_ref(input int n);
      repeat (n) @(posedge ref_clk);
      align();
   endtask

   task automatic smb_start();
      sda_m = 1'b1; #Q;
      scl_m = 1'b1; #Q;
      sda_m = 1'b0; #Q;
      scl_m = 1'b0; #Q;
   endtask

   task automatic smb_stop();
      sda_m = 1'b0; #Q;
      scl_m = 1'b1; #Q;
      sda_m = 1'b1; #Q;
   endtask

   task automatic smb_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; #Q;
         scl_m = 1'b1; #(2*Q);
         scl_m = 1'b0; #Q;
      end
      sda_m = 1'b1; #Q;
      scl_m = 1'b1; #Q;
      ack = ~sda_line;
      #Q;
      scl_m = 1'b0; #Q;
   endtask

   task automatic check_ack(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s ack actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // address, command, count, then the data bytes queued in tx_q
   task automatic frame(input logic [6:0] a, input logic rw, input string tag);
      logic ack;
      bit   hit;
      hit = (a == 7'b1101001) && !rw;
      smb_start();
      smb_byte({a, rw}, ack);              check_ack(ack, hit, tag);
      smb_byte(8'h3C, ack);                check_ack(ack, hit, tag);
      smb_byte(8'(tx_q.size()), ack);      check_ack(ack, hit, tag);
      foreach (tx_q[i]) begin
         smb_byte(tx_q[i], ack);           check_ack(ack, hit, tag);
         if (hit) begin
            pidx_q.push_back(i);
            pdat_q.push_back(tx_q[i]);
         end
      end
   endtask

   // model takes the frame at STOP; outputs are compared after a settling gap
   task automatic close_and_watch(input string tag, input int n);
      smb_stop();
      while (pidx_q.size() > 0) model_byte(pidx_q.pop_front(), pdat_q.pop_front());
      wait_ref(4);
      cur_tag = tag;
      chk_on  = 1'b1;
      wait_ref(n);
   endtask

   initial begin
      #700us;
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      sys_rst_n = 1'b0;
      scl_m     = 1'b1;
      sda_m     = 1'b1;
      pwr_dn_n  = 1'b1;
      ddr_sel   = 1'b1;
      exp_oe    = 7'h7F;
      repeat (5) @(posedge sys_clk);
      #1 sys_rst_n = 1'b1;

      // R7: reset state, all outputs running, no pull on SDA
      wait_ref(4);
      cur_tag = "R7"; chk_on = 1'b1;
      wait_ref(10);

      // R10: in-phase mode, then back to complementary
      cur_tag = "R10"; ddr_sel = 1'b0; wait_ref(10);
      ddr_sel = 1'b1; wait_ref(5);

      // R9: power-down overrides running outputs
      cur_tag = "R9"; pwr_dn_n = 1'b0; wait_ref(10);
      pwr_dn_n = 1'b1; wait_ref(4);

      // R4 / R3: byte 6 clears feedback, pair 5, pair 4
      chk_on = 1'b0;
      tx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF};
      frame(7'b1101001, 1'b0, "R4");
      close_and_watch("R4 R8", 12);

      // R5: byte 7 clears pairs 0..3, byte 6 restores the rest
      chk_on = 1'b0;
      tx_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h1A, 8'h00};
      frame(7'b1101001, 1'b0, "R5");
      close_and_watch("R5 R8", 12);
      cur_tag = "R10"; ddr_sel = 1'b0; wait_ref(8);
      ddr_sel = 1'b1; wait_ref(4);
      cur_tag = "R9"; pwr_dn_n = 1'b0; wait_ref(6);
      pwr_dn_n = 1'b1; wait_ref(4);

      // R6: only reserved bits set, every output ends disabled
      chk_on = 1'b0;
      tx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hE5, 8'h9A};
      frame(7'b1101001, 1'b0, "R6");
      close_and_watch("R6", 12);

      // R1: wrong address and a read are not acknowledged and change nothing
      chk_on = 1'b0;
      tx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      frame(7'b1101010, 1'b0, "R1");
      close_and_watch("R1", 8);
      chk_on = 1'b0;
      frame(7'b1101001, 1'b1, "R1");
      close_and_watch("R1", 8);

      // R2 / R3: bytes beyond index 7 acknowledged and discarded
      chk_on = 1'b0;
      tx_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h41,
               8'hFF, 8'hFF, 8'hFF, 8'hFF};
      frame(7'b1101001, 1'b0, "R2");
      close_and_watch("R2 R3", 12);

      // R11: repeated START inside a frame restarts byte numbering
      chk_on = 1'b0;
      tx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
      frame(7'b1101001, 1'b0, "R11");
      tx_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h1A, 8'h64};
      frame(7'b1101001, 1'b0, "R11");
      close_and_watch("R11", 12);

      // R8: re-enable a mix and watch the gated outputs
      chk_on = 1'b0;
      tx_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h18, 8'h45};
      frame(7'b1101001, 1'b0, "R8");
      close_and_watch("R8", 12);

      chk_on = 1'b0;
      wait_ref(2);
      finish_run();
   end
endmodule